// File: doc/BRIEF.md
# Late-Write Burst Static Memory

This block is a single-port synchronous static memory. It accepts a new command on every rising clock edge and needs no idle cycle when the bus switches between reads and writes. A command carries an address and byte-lane write strobes. The write data for a write command arrives one or two edges after its address, set by a static mode pin. In pipelined mode, read data passes through an extra output register. In flow-through mode, read data leaves the array one edge earlier.

A load command starts a burst. It is accepted only when all three select inputs are active, and otherwise it is a deselect. Advance cycles then step the two low address bits through a four-beat sequence. The sequence is linear or interleaved, set by a static pin, and wraps after four beats.

A read always returns the data of every earlier write, in command order. This holds even when the earlier write's data has not yet reached the array: the word is merged per byte lane with what the array holds. Each 9-bit lane carries its own parity bit in bit 8 of the lane. Write data is checked against the selected parity sense, and a mismatch gives a one-cycle error pulse for that lane.

The data pins are plain. Each port has its own direction, with a separate driver-enable output in place of a tri-stated bus. The interface has no back-pressure: every cycle is consumed.

Top module: `lwsram_core`

## Requirements
- R1: A load cycle (`burst_next`=0) starts a command only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0 are all present at that edge. Any other combination is a deselect: nothing is written, no read data appears, and advance cycles that follow it stay deselected.
- R2: A read sampled at edge k shows its data on `rdata`, with `rdata_drive`=1, during the cycle after edge k+1 when `flow_thru`=1. When `flow_thru`=0, this happens during the cycle after edge k+2. Each burst beat follows one cycle after the previous one.
- R3: The write data for a write sampled at edge k is taken from `wdata` at edge k+1 when `flow_thru`=1, and at edge k+2 when `flow_thru`=0.
- R4: Reads and writes may follow one another on consecutive edges. A read returns, per byte lane, the most recent earlier write to that address, including a write whose data has not yet reached the array.
- R5: With `burst_next`=1 after an accepted load, the next beat keeps address bits above bit 1. Bits [1:0] become (start+n) mod 4 when `order_linear`=1, and start XOR n when `order_linear`=0, where n counts beats since the load (mod 4). On advance cycles, `addr`, `we_n` and the select inputs are ignored.
- R6: `lane_wr_n[b]` is active-low and controls bits [9b+8:9b]. It is sampled with each load or beat. Only the enabled lanes are written, and the lane strobes present when the data arrives have no effect.
- R7: `oe_n`=1 forces `rdata_drive`=0 and `rdata`=0 at once, without waiting for a clock. When no read data is due, `rdata_drive`=0 and `rdata`=0.
- R8: Bit 8 of each lane is its parity bit. `par_odd`=0 requires an even count of ones in the lane's 9 bits, and `par_odd`=1 requires an odd count. `par_err[b]` goes high for one cycle after the edge that takes in write data for an enabled lane b that fails this check. The data is stored anyway.
- R9: While `rst_n` is low, and after it is released, `rdata_drive`=0, `rdata`=0 and `par_err`=0, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | Static: 1 flow-through / single late write, 0 pipelined / double late write |
| order_linear | input | 1 | Static: 1 linear burst order, 0 interleaved |
| par_odd | input | 1 | Static: 1 odd lane parity, 0 even |
| burst_next | input | 1 | 0 load a new command, 1 advance current burst |
| we_n | input | 1 | Active-low write select, sampled on load |
| en_a_n | input | 1 | Active-low select |
| en_b | input | 1 | Active-high select |
| en_c_n | input | 1 | Active-low select |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| addr | input | AW | Word address, sampled on load |
| wdata | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | Output driver enable for `rdata` |
| par_err | output | LANES | Per-lane write parity error pulse |

## Verification
The case that matters most is a read that is captured on the same edge as a still-pending write to the same address is committed. The read has to merge that write's arriving data with the stored word, per lane. The bench provokes this by following a partial-lane write at once with a read of the same address, and also of a neighbouring address. It does this in both modes, so the forwarding path and the array path are each exercised. Every returned word is compared with a command-order reference memory, built from the bench's own lane arithmetic. The same runs also inject parity errors into lanes whose strobes are on and into lanes whose strobes are off.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
package lwsram_pkg;
  // Beats per burst are fixed at four: two low address bits.
  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits of beat n of a burst that began at start.
  function automatic beat_t beat_offset(beat_t start, beat_t n, logic linear);
    beat_t sum;
    sum = start + n;
    return linear ? sum : (start ^ n);
  endfunction
endpackage

// File: rtl/lwsram_burst_seq.sv
`timescale 1ns/1ps
module lwsram_burst_seq
  import lwsram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             order_linear,
  input  logic             burst_next,
  input  logic             we_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic [AW-1:0]    cmd_addr,
  output logic [LANES-1:0] cmd_be
);
  logic             act_q;
  logic             wr_q;
  logic [AW-1:0]    base_q;
  beat_t            cnt_q;
  logic [LANES-1:0] be_q;
  logic             selected;

  assign selected = ~en_a_n & en_b & ~en_c_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else begin
      be_q <= ~lane_wr_n;
      if (!burst_next) begin
        act_q  <= selected;
        wr_q   <= ~we_n;
        base_q <= addr;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q <= cnt_q + beat_t'(1);
      end
    end
  end

  assign cmd_rd   = act_q & ~wr_q;
  assign cmd_wr   = act_q & wr_q;
  assign cmd_be   = be_q;
  assign cmd_addr = {base_q[AW-1:BEAT_W], beat_offset(base_q[BEAT_W-1:0], cnt_q, order_linear)};

  // R1
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_next && !selected) |=> !(cmd_rd || cmd_wr));

  // R5
  burst_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && burst_next) |=> (cmd_addr[AW-1:BEAT_W] == $past(cmd_addr[AW-1:BEAT_W])));

  // R5
  burst_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && burst_next && order_linear) |=>
      (cmd_addr[BEAT_W-1:0] == beat_t'($past(cmd_addr[BEAT_W-1:0]) + beat_t'(1))));
endmodule

// File: rtl/lwsram_write_pipe.sv
`timescale 1ns/1ps
module lwsram_write_pipe #(
  parameter int AW     = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_thru,
  input  logic             par_odd,
  input  logic             cmd_wr,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [LANES-1:0] cmd_be,
  input  logic [W-1:0]     wdata,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_be,
  output logic [LANES-1:0] par_err
);
  // One extra slot holds a write for the double late write mode.
  logic             p1_v;
  logic [AW-1:0]    p1_addr;
  logic [LANES-1:0] p1_be;
  logic [LANES-1:0] lane_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v    <= 1'b0;
      p1_addr <= '0;
      p1_be   <= '0;
    end else begin
      p1_v    <= cmd_wr;
      p1_addr <= cmd_addr;
      p1_be   <= cmd_be;
    end
  end

  // Commit point: the stage whose data is on wdata at this edge.
  assign wr_en   = flow_thru ? cmd_wr   : p1_v;
  assign wr_addr = flow_thru ? cmd_addr : p1_addr;
  assign wr_be   = flow_thru ? cmd_be   : p1_be;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = (^wdata[g*LANE_W +: LANE_W]) ^ par_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_err <= '0;
    else        par_err <= wr_en ? (wr_be & lane_bad) : '0;
  end

  // R8
  perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|par_err) |-> $past(wr_en));
endmodule

// File: rtl/lwsram_store.sv
`timescale 1ns/1ps
module lwsram_store #(
  parameter int AW     = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_be,
  input  logic [W-1:0]     wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_v,
  output logic [W-1:0]     rd_q
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] fwd;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  // The write committing on this edge is not yet in mem: merge it per lane.
  always_comb begin
    fwd = mem[rd_addr];
    if (wr_en && (wr_addr == rd_addr)) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) fwd[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v <= 1'b0;
      rd_q <= '0;
    end else begin
      rd_v <= rd_en;
      if (rd_en) rd_q <= fwd;
    end
  end
endmodule

// File: rtl/lwsram_core.sv
`timescale 1ns/1ps
module lwsram_core #(
  parameter int AW     = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_thru,
  input  logic                    order_linear,
  input  logic                    par_odd,
  input  logic                    burst_next,
  input  logic                    we_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive,
  output logic [LANES-1:0]        par_err
);
  localparam int W = LANES * LANE_W;

  logic             cmd_rd, cmd_wr;
  logic [AW-1:0]    cmd_addr;
  logic [LANES-1:0] cmd_be;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [LANES-1:0] wr_be;
  logic             rd1_v, rd2_v, out_v;
  logic [W-1:0]     rd1_q, rd2_q, out_q;

  lwsram_burst_seq #(.AW(AW), .LANES(LANES)) seq_i (
    .clk(clk), .rst_n(rst_n), .order_linear(order_linear),
    .burst_next(burst_next), .we_n(we_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .lane_wr_n(lane_wr_n), .addr(addr),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
  );

  lwsram_write_pipe #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) wpipe_i (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .par_odd(par_odd),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be), .wdata(wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .par_err(par_err)
  );

  lwsram_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wdata(wdata),
    .rd_en(cmd_rd), .rd_addr(cmd_addr),
    .rd_v(rd1_v), .rd_q(rd1_q)
  );

  // Output register used only by the pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd2_v <= 1'b0;
      rd2_q <= '0;
    end else begin
      rd2_v <= rd1_v;
      rd2_q <= rd1_q;
    end
  end

  assign out_v       = flow_thru ? rd1_v : rd2_v;
  assign out_q       = flow_thru ? rd1_q : rd2_q;
  assign rdata_drive = out_v & ~oe_n;
  assign rdata       = rdata_drive ? out_q : '0;

  // R2
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && rd1_v) |-> $past(cmd_rd));

  // R2
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && rd2_v) |-> $past(cmd_rd, 2));
endmodule

// File: tb/lwsram_core_tb_top.sv
`timescale 1ns/1ps
module lwsram_core_tb_top;
  localparam int AW = 4, LANES = 2, LANE_W = 9, W = 18, DEPTH = 16;
  localparam logic [2:0] SEL_OK = 3'b010; // {en_a_n, en_b, en_c_n}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic flow_thru = 1'b0, order_linear = 1'b1, par_odd = 1'b0;
  logic burst_next = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic rdata_drive;
  logic [LANES-1:0] par_err;

  lwsram_core #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .order_linear(order_linear),
    .par_odd(par_odd), .burst_next(burst_next), .we_n(we_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_drive(rdata_drive), .par_err(par_err)
  );

  int checks = 0, errors = 0, s = 0;
  logic [W-1:0] m [DEPTH];
  bit ev [8];
  logic [W-1:0] eq [8];
  string et [8];
  logic [1:0] epe [8];
  logic [W-1:0] ds [8];
  bit dv [8];
  bit b_act = 0, b_wr = 0;
  logic [3:0] b_base = 0;
  logic [1:0] b_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkword(logic [3:0] ea, logic [7:0] seed, bit odd, logic [1:0] bad);
    logic [W-1:0] w;
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] b;
      b = 8'(int'(ea) * 37 + int'(seed) * 11 + l * 91 + 5);
      w[l*9 +: 9] = {(^b) ^ odd ^ bad[l], b};
    end
    return w;
  endfunction

  task automatic step(input bit ld, input bit wr, input logic [2:0] sel, input logic [1:0] be,
                      input logic [3:0] a, input logic [7:0] seed, input logic [1:0] bad,
                      input string tag);
    int r, dl, rl;
    logic [3:0] ea;
    logic [1:0] lo;
    logic [W-1:0] wd;
    r  = s % 8;
    dl = flow_thru ? 1 : 2;
    rl = flow_thru ? 2 : 3;
    if (ev[r] && (s % 3 == 0)) begin
      oe_n = 1'b1;
      #0.3;
      chk(!rdata_drive && rdata == 0, "R7", "oe_n high forces bus off", {13'd0, rdata_drive, rdata}, 0);
      oe_n = 1'b0;
      #0.3;
    end
    if (ev[r])
      chk(rdata_drive && rdata == eq[r], et[r], "read data", {13'd0, rdata_drive, rdata}, {13'd0, 1'b1, eq[r]});
    else
      chk(!rdata_drive && rdata == 0, "R7", "idle bus", {13'd0, rdata_drive, rdata}, 0);
    chk(par_err == epe[r], "R8", "parity flags", {30'd0, par_err}, {30'd0, epe[r]});
    ev[r] = 0;
    epe[r] = 0;
    burst_next = !ld;
    we_n = !wr;
    {en_a_n, en_b, en_c_n} = sel;
    lane_wr_n = ~be;
    addr = ld ? a : (a ^ 4'(s));
    wdata = dv[r] ? ds[r] : {s[8:0], ~s[8:0]};
    dv[r] = 0;
    if (ld) begin
      b_act = (sel == SEL_OK); b_wr = wr; b_base = a; b_cnt = 0;
    end else if (b_act) begin
      b_cnt = b_cnt + 2'd1;
    end
    lo = order_linear ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
    ea = {b_base[3:2], lo};
    if (b_act) begin
      if (b_wr) begin
        wd = mkword(ea, seed, par_odd, bad);
        for (int l = 0; l < LANES; l++) if (be[l]) m[ea][l*9 +: 9] = wd[l*9 +: 9];
        ds[(s + dl) % 8] = wd;
        dv[(s + dl) % 8] = 1;
        epe[(s + dl + 1) % 8] = be & bad;
      end else begin
        ev[(s + rl) % 8] = 1;
        eq[(s + rl) % 8] = m[ea];
        et[(s + rl) % 8] = {"R2+", tag};
      end
    end
    s++;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit f, input bit l, input bit o);
    rst_n = 1'b0;
    flow_thru = f; order_linear = l; par_odd = o;
    burst_next = 1'b0;
    {en_a_n, en_b, en_c_n} = 3'b110;
    repeat (2) @(negedge clk);
    chk(!rdata_drive && rdata == 0 && par_err == 0, "R9", "reset state",
        {11'd0, par_err, rdata_drive, rdata}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin ev[i] = 0; epe[i] = 0; dv[i] = 0; end
    b_act = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual cycles=20000 expected fewer");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      do_reset(p[0], p[1], p[0] ^ p[1]);
      // R3: fill the array with four-beat write bursts
      for (int b = 0; b < 4; b++) begin
        step(1, 1, SEL_OK, 2'b11, 4'(b * 4), 8'(p), 2'b00, "R3");
        for (int k = 0; k < 3; k++) step(0, 0, 3'b111, 2'b11, 4'(k), 8'(p), 2'b00, "R3");
      end
      // R5: read bursts from every start address, beats back to back
      for (int a = 0; a < DEPTH; a++) begin
        step(1, 0, SEL_OK, 2'b00, 4'(a), 0, 0, "R5");
        for (int k = 0; k < 3; k++) step(0, 1, 3'b101, 2'b11, 4'(k), 0, 0, "R5");
      end
      // R4: partial writes immediately followed by reads of same and neighbour
      for (int a = 0; a < DEPTH; a++) begin
        step(1, 1, SEL_OK, 2'b01, 4'(a), 8'(a + 40), 2'b00, "R4");
        step(1, 0, SEL_OK, 2'b11, 4'(a), 0, 0, "R4");
        step(1, 1, SEL_OK, 2'b10, 4'(a), 8'(a + 90), 2'b00, "R4");
        step(1, 0, SEL_OK, 2'b00, 4'(a ^ 1), 0, 0, "R4");
        step(1, 0, SEL_OK, 2'b00, 4'(a), 0, 0, "R4");
      end
      // R6: strobes taken with the command, not with the late data
      step(1, 1, SEL_OK, 2'b01, 4'd3, 8'd77, 2'b00, "R6");
      step(1, 0, 3'b110, 2'b11, 4'd3, 0, 0, "R6");
      step(1, 0, 3'b000, 2'b11, 4'd3, 0, 0, "R6");
      step(1, 0, SEL_OK, 2'b11, 4'd3, 0, 0, "R6");
      step(1, 1, SEL_OK, 2'b10, 4'd9, 8'd66, 2'b00, "R6");
      step(0, 0, 3'b000, 2'b01, 4'd0, 8'd67, 2'b00, "R6");
      step(0, 0, 3'b000, 2'b00, 4'd0, 8'd68, 2'b00, "R6");
      step(0, 0, 3'b000, 2'b11, 4'd0, 8'd69, 2'b00, "R6");
      step(1, 0, SEL_OK, 2'b00, 4'd9, 0, 0, "R6");
      for (int k = 0; k < 3; k++) step(0, 1, 3'b000, 2'b11, 4'(k), 0, 0, "R6");
      // R1: each failing select pattern, then advances after a deselect
      step(1, 1, 3'b110, 2'b11, 4'd5, 8'd99, 2'b00, "R1");
      step(1, 1, 3'b000, 2'b11, 4'd5, 8'd98, 2'b00, "R1");
      step(1, 1, 3'b011, 2'b11, 4'd5, 8'd97, 2'b00, "R1");
      step(0, 1, SEL_OK, 2'b11, 4'd5, 8'd96, 2'b00, "R1");
      step(1, 0, 3'b111, 2'b00, 4'd5, 0, 0, "R1");
      step(0, 0, SEL_OK, 2'b00, 4'd5, 0, 0, "R1");
      step(1, 0, SEL_OK, 2'b00, 4'd5, 0, 0, "R1");
      // R8: bad parity on enabled lanes, and on a disabled lane
      step(1, 1, SEL_OK, 2'b11, 4'd6, 8'd20, 2'b01, "R8");
      step(1, 1, SEL_OK, 2'b11, 4'd7, 8'd21, 2'b10, "R8");
      step(1, 1, SEL_OK, 2'b10, 4'd6, 8'd22, 2'b01, "R8");
      step(1, 0, SEL_OK, 2'b00, 4'd6, 0, 0, "R8");
      step(1, 0, SEL_OK, 2'b00, 4'd7, 0, 0, "R8");
      // flush pending results
      for (int k = 0; k < 4; k++) step(1, 0, 3'b110, 2'b11, 4'd0, 0, 0, "R7");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule